// File: doc/BRIEF.md
# Flash Write Sequencer

This block stands between a register-mapped bus port and a simple flash array port. Software places a byte address, pushes 32-bit data words into a small write buffer and issues one of three commands: erase the page that holds the address, program a stream of words at rising addresses, or program a single word. The sequencer holds program or erase strobes toward the flash array until the array returns a done pulse. Every outcome is reported in one read-only status word.

The status word shows whether the sequencer is busy and whether it can take another data word. It shows how full the buffer is, with one bit for each valid entry. It also holds four sticky outcome flags: the word stream timed out, an address outside the flash, a locked page, and an erase cut short by an interrupt. A streaming write that receives no data word within the timeout window ends by itself and returns the flash to the bus. Each 2 KB page can be protected by one bit of a lock mask input.

Top module: `flash_wr_seq`

## Requirements
- R1: After reset the status word reads 0x0000_0002 (only the ready bit 1 is set), and the erase and program strobes and the ownership output are low.
- R2: Status bit 1 (data ready) goes low in the cycle after any data register write (reg_sel = 1). It goes high again when the sequencer moves a buffered word to the flash data output, or when a write sequence ends.
- R3: Status bits 11:8 show the buffer fill level as a thermometer code: bit 8+i is set while more than i words are held. A data write to a full buffer is dropped. Words left in the buffer when a write sequence ends are discarded.
- R4: Command code 2 (reg_sel = 2, reg_wdata[1:0] = 2) programs the buffered words in arrival order at byte addresses that start at the loaded address and rise by 4. fl_prog stays high until fl_done, and fl_prog and fl_erase are never high together.
- R5: Command code 3 programs exactly one word and then returns to idle without setting the timeout flag.
- R6: During a streaming write, if no word is buffered for TMO_RELOAD+1 consecutive cycles, the sequence ends: status bit 2 (timeout) sets, and busy (bit 0) and seq_owns_flash fall in that same cycle. The window restarts after each programmed word.
- R7: The timeout flag clears when the next erase or write command is accepted.
- R8: While busy, commands and address loads (reg_sel = 0) are ignored, and the loaded address and the running operation are unchanged.
- R9: Loading an address at or above FLASH_BYTES sets status bit 3. A command accepted while that address is loaded starts nothing and leaves bit 3 set. A streaming write that steps past the end of the flash stops with bit 3 set.
- R10: If lock_mask bit (address / 2048) is 1, an erase or a word write to that page starts nothing and status bit 4 sets. A streaming write that reaches a locked page stops there.
- R11: Command code 1 holds fl_erase high with fl_addr aligned down to the 2 KB page boundary until fl_done.
- R12: irq high during an erase, in a cycle without fl_done, drops fl_erase, ends the erase and sets status bit 5. If fl_done and irq arrive in the same cycle, the erase completes and bit 5 stays clear.
- R13: Status bits 3, 4 and 5 stay set until the next command is accepted, and are then cleared (bit 3 is then set again if the loaded address is invalid).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 command |
| reg_wdata | input | 32 | Register write value |
| lock_mask | input | 32 | Per-page lock bits, 1 = locked |
| irq | input | 1 | Interrupt that aborts an erase |
| fl_erase | output | 1 | Erase strobe, held until done |
| fl_prog | output | 1 | Program strobe, held until done |
| fl_addr | output | 32 | Flash byte address |
| fl_wdata | output | 32 | Word to program |
| fl_done | input | 1 | Flash operation complete pulse |
| seq_owns_flash | output | 1 | Sequencer holds the flash; low means the bus has it |
| status | output | 32 | Read-only status word |

## Verification
A stuck or wrong sequencer state shows at the ports in the next cycle: a strobe that fails to rise, a busy bit that does not match the strobe, or a busy bit that stays high past the timeout window. A wrong buffer pointer or count shows as words programmed out of order, at the wrong addresses, or with the wrong thermometer bits. These appear by the next done pulse. A timer that is off by one shifts the timeout flag by a cycle, and an exact count from command acceptance catches this. A flag that clears too early or too late shows when the status word is sampled just before and just after the next accepted command.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CMD  = 2'd2,
      SEL_NONE = 2'd3
   } fsq_sel_e;

   typedef enum logic [1:0] {
      CMD_NOP   = 2'd0,
      CMD_ERASE = 2'd1,
      CMD_WTRIG = 2'd2,
      CMD_WONCE = 2'd3
   } fsq_cmd_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_ERASE,
      S_WAIT,
      S_PROG
   } fsq_state_e;

   typedef struct packed {
      logic aborted;
      logic locked;
      logic bad_addr;
      logic timeout;
   } fsq_err_t;

   localparam int ST_BUSY    = 0;
   localparam int ST_READY   = 1;
   localparam int ST_TMO     = 2;
   localparam int ST_BADADDR = 3;
   localparam int ST_LOCKED  = 4;
   localparam int ST_ABORT   = 5;
   localparam int ST_OCC_LSB = 8;

endpackage

// File: rtl/fsq_wbuf.sv
module fsq_wbuf #(
   parameter int DEPTH = 4,
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full,
   output logic [DEPTH-1:0] occ
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1 || DEPTH > 8) begin : g_bad_depth
      $error("fsq_wbuf: DEPTH must lie in 1..8");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count;
   logic             do_push, do_pop;

   function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= ptr_next(wr_ptr);
         if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_occ
      assign occ[i] = (count > CW'(i));
   end

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> full);

   a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);

endmodule

// File: rtl/fsq_timer.sv
module fsq_timer #(
   parameter int CW     = 16,
   parameter int RELOAD = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);

   if (RELOAD < 1 || RELOAD >= (1 << CW)) begin : g_bad_reload
      $error("fsq_timer: RELOAD must fit in CW bits and be nonzero");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= CW'(RELOAD);
      else if (load)              cnt <= CW'(RELOAD);
      else if (run && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !run) |=> $stable(cnt));

   a_r6_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && run && !expired) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/fsq_addr_chk.sv
module fsq_addr_chk #(
   parameter int FLASH_BYTES = 65536,
   parameter int PAGE_BYTES  = 2048
) (
   input  logic [31:0] addr,
   input  logic [31:0] lock_mask,
   output logic        out_of_range,
   output logic        page_locked,
   output logic [31:0] page_base
);

   localparam int PAGES = FLASH_BYTES / PAGE_BYTES;
   localparam int PB    = $clog2(PAGE_BYTES);
   localparam int PIW   = (PAGES > 1) ? $clog2(PAGES) : 1;

   if ((1 << PB) != PAGE_BYTES || PAGES * PAGE_BYTES != FLASH_BYTES
       || PAGES < 1 || PAGES > 32) begin : g_bad_geom
      $error("fsq_addr_chk: page size must be a power of two, 1..32 whole pages");
   end

   assign out_of_range = ({1'b0, addr} >= 33'(FLASH_BYTES));
   assign page_base    = {addr[31:PB], {PB{1'b0}}};

   if (PAGES == 1) begin : g_one_page
      assign page_locked = lock_mask[0];
   end else begin : g_many_pages
      logic [PIW-1:0] page_idx;
      assign page_idx    = addr[PB +: PIW];
      assign page_locked = lock_mask[page_idx];
   end

endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
   import fsq_pkg::*;
#(
   parameter int FLASH_BYTES = 65536,
   parameter int PAGE_BYTES  = 2048,
   parameter int BUF_DEPTH   = 4,
   parameter int TMO_BITS    = 16,
   parameter int TMO_RELOAD  = 1000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [1:0]  reg_sel,
   input  logic [31:0] reg_wdata,
   input  logic [31:0] lock_mask,
   input  logic        irq,
   output logic        fl_erase,
   output logic        fl_prog,
   output logic [31:0] fl_addr,
   output logic [31:0] fl_wdata,
   input  logic        fl_done,
   output logic        seq_owns_flash,
   output logic [31:0] status
);

   localparam int PB = $clog2(PAGE_BYTES);

   if (BUF_DEPTH > ST_OCC_LSB + 8 || ST_OCC_LSB + BUF_DEPTH > 32) begin : g_bad_occ
      $error("flash_wr_seq: occupancy field does not fit the status word");
   end

   fsq_state_e           state;
   fsq_err_t             err;
   logic [31:0]          addr_q;
   logic [31:0]          wd_q;
   logic                 once_q;
   logic                 ready_q;

   fsq_cmd_e             cmd_code;
   logic                 cmd_hit, accept, addr_ld, push;
   logic                 oor, lk;
   logic [31:0]          page_base;
   logic                 new_oor;
   logic                 buf_empty, buf_full, pop, flush;
   logic [31:0]          buf_dout;
   logic [BUF_DEPTH-1:0] occ;
   logic                 tmr_load, tmr_run, tmr_expired;
   logic                 word_ok;

   assign cmd_code = fsq_cmd_e'(reg_wdata[1:0]);
   assign cmd_hit  = reg_wr && (reg_sel == 2'(SEL_CMD)) && (cmd_code != CMD_NOP);
   assign accept   = cmd_hit && (state == S_IDLE);
   assign addr_ld  = reg_wr && (reg_sel == 2'(SEL_ADDR)) && (state == S_IDLE);
   assign push     = reg_wr && (reg_sel == 2'(SEL_DATA));
   assign new_oor  = ({1'b0, reg_wdata} >= 33'(FLASH_BYTES));

   fsq_addr_chk #(
      .FLASH_BYTES (FLASH_BYTES),
      .PAGE_BYTES  (PAGE_BYTES)
   ) i_chk (
      .addr         (addr_q),
      .lock_mask    (lock_mask),
      .out_of_range (oor),
      .page_locked  (lk),
      .page_base    (page_base)
   );

   assign word_ok = (state == S_WAIT) && !buf_empty && !oor && !lk;
   assign pop     = word_ok;
   assign flush   = ((state == S_WAIT) && !buf_empty && (oor || lk))
                 || ((state == S_WAIT) && buf_empty && tmr_expired)
                 || ((state == S_PROG) && fl_done && once_q);

   fsq_wbuf #(
      .DEPTH (BUF_DEPTH),
      .WIDTH (32)
   ) i_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .flush (flush),
      .din   (reg_wdata),
      .dout  (buf_dout),
      .empty (buf_empty),
      .full  (buf_full),
      .occ   (occ)
   );

   assign tmr_load = accept || ((state == S_PROG) && fl_done);
   assign tmr_run  = (state == S_WAIT) && buf_empty;

   fsq_timer #(
      .CW     (TMO_BITS),
      .RELOAD (TMO_RELOAD)
   ) i_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .run     (tmr_run),
      .expired (tmr_expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b1;
      end else if (flush) begin
         ready_q <= 1'b1;
      end else if (push) begin
         ready_q <= 1'b0;
      end else if (pop) begin
         ready_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         err    <= '0;
         addr_q <= '0;
         wd_q   <= '0;
         once_q <= 1'b0;
      end else begin
         case (state)
            S_IDLE: begin
               if (accept) begin
                  err          <= '0;
                  err.bad_addr <= oor;
                  err.locked   <= !oor && lk;
                  once_q       <= (cmd_code == CMD_WONCE);
                  if (!oor && !lk) begin
                     state <= (cmd_code == CMD_ERASE) ? S_ERASE : S_WAIT;
                  end
               end else if (addr_ld) begin
                  addr_q <= {reg_wdata[31:2], 2'b00};
                  if (new_oor) err.bad_addr <= 1'b1;
               end
            end
            S_ERASE: begin
               if (fl_done) begin
                  state <= S_IDLE;
               end else if (irq) begin
                  err.aborted <= 1'b1;
                  state       <= S_IDLE;
               end
            end
            S_WAIT: begin
               if (!buf_empty) begin
                  if (oor) begin
                     err.bad_addr <= 1'b1;
                     state        <= S_IDLE;
                  end else if (lk) begin
                     err.locked <= 1'b1;
                     state      <= S_IDLE;
                  end else begin
                     wd_q  <= buf_dout;
                     state <= S_PROG;
                  end
               end else if (tmr_expired) begin
                  err.timeout <= 1'b1;
                  state       <= S_IDLE;
               end
            end
            S_PROG: begin
               if (fl_done) begin
                  addr_q <= addr_q + 32'd4;
                  state  <= once_q ? S_IDLE : S_WAIT;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign fl_erase       = (state == S_ERASE);
   assign fl_prog        = (state == S_PROG);
   assign fl_addr        = (state == S_ERASE) ? page_base : addr_q;
   assign fl_wdata       = wd_q;
   assign seq_owns_flash = (state != S_IDLE);

   always_comb begin
      status                            = '0;
      status[ST_BUSY]                   = (state != S_IDLE);
      status[ST_READY]                  = ready_q;
      status[ST_TMO]                    = err.timeout;
      status[ST_BADADDR]                = err.bad_addr;
      status[ST_LOCKED]                 = err.locked;
      status[ST_ABORT]                  = err.aborted;
      status[ST_OCC_LSB +: BUF_DEPTH]   = occ;
   end

   a_r4_prog_held: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_prog && !fl_done) |=> fl_prog);

   a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_prog && fl_erase));

   a_r11_erase_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      fl_erase |-> (fl_addr[PB-1:0] == '0));

   a_r8_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_erase && reg_wr) |=> $stable(addr_q));

   a_r12_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err.aborted) |-> ($past(irq) && $past(fl_erase) && !$past(fl_done)));

   a_r6_timeout_releases: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err.timeout) |-> !seq_owns_flash);

   a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush) |=> !status[ST_READY]);

endmodule

// File: tb/test_flash_wr_seq.sv
module test_flash_wr_seq;

   localparam int CLK_PERIOD = 10;
   localparam int FLASH      = 65536;
   localparam int TMO        = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd3;
   logic [31:0] reg_wdata = '0;
   logic [31:0] lock_mask = '0;
   logic        irq = 1'b0;
   logic        fl_erase, fl_prog, fl_done, seq_owns_flash;
   logic [31:0] fl_addr, fl_wdata, status;

   int n_tests = 0;
   int n_fail  = 0;
   bit run_done = 1'b0;
   int model_dly = 3;
   int cnt_m;
   int lg_n;
   logic [31:0] lg_addr [256];
   logic [31:0] lg_data [256];
   logic [1:0]  lg_kind [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_wr_seq #(
      .FLASH_BYTES (FLASH),
      .PAGE_BYTES  (2048),
      .BUF_DEPTH   (4),
      .TMO_BITS    (16),
      .TMO_RELOAD  (TMO)
   ) i_flash_wr_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .reg_wr         (reg_wr),
      .reg_sel        (reg_sel),
      .reg_wdata      (reg_wdata),
      .lock_mask      (lock_mask),
      .irq            (irq),
      .fl_erase       (fl_erase),
      .fl_prog        (fl_prog),
      .fl_addr        (fl_addr),
      .fl_wdata       (fl_wdata),
      .fl_done        (fl_done),
      .seq_owns_flash (seq_owns_flash),
      .status         (status)
   );

   // flash array model: done pulse after model_dly+1 strobe cycles, logs completed ops
   always @(posedge clk) begin
      if (!rst_n) begin
         fl_done <= 1'b0;
         cnt_m   <= 0;
         lg_n    <= 0;
      end else begin
         fl_done <= 1'b0;
         if ((fl_prog || fl_erase) && !fl_done) begin
            if (cnt_m >= model_dly) begin
               fl_done <= 1'b1;
               cnt_m   <= 0;
               lg_addr[lg_n[7:0]] <= fl_addr;
               lg_data[lg_n[7:0]] <= fl_wdata;
               lg_kind[lg_n[7:0]] <= fl_erase ? 2'd1 : 2'd2;
               lg_n    <= lg_n + 1;
            end else begin
               cnt_m <= cnt_m + 1;
            end
         end else begin
            cnt_m <= 0;
         end
      end
   end

   function automatic logic [31:0] exp_st(bit busy, bit rdy, bit tmo, bit bad,
                                          bit lck, bit abt, int occ);
      logic [31:0] r;
      r       = '0;
      r[0]    = busy;
      r[1]    = rdy;
      r[2]    = tmo;
      r[3]    = bad;
      r[4]    = lck;
      r[5]    = abt;
      r[11:8] = 4'((1 << occ) - 1);
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic reg_write(logic [1:0] sel, logic [31:0] val);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_sel   = sel;
      reg_wdata = val;
      @(negedge clk);
      reg_wr    = 1'b0;
      reg_sel   = 2'd3;
   endtask

   task automatic wait_idle(string req);
      for (int i = 0; i < 400; i++) begin
         if (!status[0]) return;
         @(negedge clk);
      end
      chk(req, {31'b0, status[0]}, 32'd0);
   endtask

   task automatic wait_ready(string req);
      for (int i = 0; i < 60; i++) begin
         if (status[1]) return;
         @(negedge clk);
      end
      chk(req, {31'b0, status[1]}, 32'd1);
   endtask

   task automatic chk_log(string req, int idx, logic [1:0] kind,
                          logic [31:0] a, logic [31:0] d);
      chk(req, {30'b0, lg_kind[idx]}, {30'b0, kind});
      chk(req, lg_addr[idx], a);
      if (kind == 2'd2) chk(req, lg_data[idx], d);
   endtask

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      if (!run_done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int base;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 status", status, exp_st(0,1,0,0,0,0,0));
      chk("R1 strobes", {29'b0, fl_prog, fl_erase, seq_owns_flash}, 32'd0);

      // R2 R5 single word write
      base = lg_n;
      reg_write(2'd0, 32'h100);
      reg_write(2'd1, 32'hA5A5_0001);
      chk("R2 ready low after data write", status, exp_st(0,0,0,0,0,0,1));
      reg_write(2'd2, 32'd3);
      chk("R5 accepted, waiting", status, exp_st(1,0,0,0,0,0,1));
      @(negedge clk);
      chk("R2 ready back on pop", status, exp_st(1,1,0,0,0,0,0));
      chk("R4 prog strobe", {31'b0, fl_prog}, 32'd1);
      chk("R4 prog addr", fl_addr, 32'h100);
      chk("R4 prog data", fl_wdata, 32'hA5A5_0001);
      wait_idle("R5 finish");
      chk("R5 end status", status, exp_st(0,1,0,0,0,0,0));
      chk("R5 one word", lg_n - base, 1);
      chk_log("R5 log", base, 2'd2, 32'h100, 32'hA5A5_0001);

      // R6 exact timeout window
      reg_write(2'd0, 32'h200);
      reg_write(2'd2, 32'd2);
      repeat (TMO) @(negedge clk);
      chk("R6 still waiting at window end", {31'b0, status[0]}, 32'd1);
      @(negedge clk);
      chk("R6 timeout status", status, exp_st(0,1,1,0,0,0,0));
      chk("R6 flash handed back", {31'b0, seq_owns_flash}, 32'd0);

      // R7 R11 erase clears timeout
      base = lg_n;
      reg_write(2'd0, 32'h0000_0A34);
      reg_write(2'd2, 32'd1);
      chk("R7 timeout cleared", status, exp_st(1,1,0,0,0,0,0));
      chk("R11 erase aligned", fl_addr, 32'h0000_0800);
      wait_idle("R11 finish");
      chk_log("R11 log", base, 2'd1, 32'h800, 32'h0);

      // R3 fill, overflow drop, order
      base = lg_n;
      for (int k = 0; k < 4; k++) reg_write(2'd1, 32'hC0DE_0000 + k);
      chk("R3 four held", status, exp_st(0,0,0,0,0,0,4));
      reg_write(2'd1, 32'hDEAD_BEEF);
      chk("R3 full write dropped", status, exp_st(0,0,0,0,0,0,4));
      reg_write(2'd0, 32'h1000);
      reg_write(2'd2, 32'd2);
      wait_idle("R3 finish");
      chk("R3 four programmed", lg_n - base, 4);
      for (int k = 0; k < 4; k++)
         chk_log("R4 order", base + k, 2'd2, 32'h1000 + 4*k, 32'hC0DE_0000 + k);
      chk("R6 timeout after stream", status, exp_st(0,1,1,0,0,0,0));

      // R8 ignored while busy
      model_dly = 30;
      reg_write(2'd0, 32'h1804);
      reg_write(2'd2, 32'd1);
      chk("R11 page base", fl_addr, 32'h1800);
      repeat (3) @(negedge clk);
      reg_write(2'd0, 32'h4000);
      reg_write(2'd2, 32'd2);
      chk("R8 erase unchanged", {fl_addr[30:0], fl_erase}, {31'h1800, 1'b1});
      wait_idle("R8 finish");
      repeat (3) @(negedge clk);
      chk("R8 no new op", status, exp_st(0,1,0,0,0,0,0));
      model_dly = 3;
      reg_write(2'd2, 32'd1);
      chk("R8 address kept", fl_addr, 32'h1800);
      wait_idle("R8 finish2");

      // R9 invalid address
      base = lg_n;
      reg_write(2'd0, FLASH);
      chk("R9 flag on load", {31'b0, status[3]}, 32'd1);
      reg_write(2'd2, 32'd3);
      chk("R9 command no-op", status, exp_st(0,1,0,1,0,0,0));
      reg_write(2'd0, 32'h40);
      chk("R13 flag sticky", {31'b0, status[3]}, 32'd1);
      reg_write(2'd2, 32'd1);
      chk("R13 flag cleared on accept", status, exp_st(1,1,0,0,0,0,0));
      wait_idle("R9 finish");
      chk("R9 only the erase ran", lg_n - base, 1);

      // R9 stream runs off the end
      base = lg_n;
      reg_write(2'd0, FLASH - 4);
      reg_write(2'd2, 32'd2);
      reg_write(2'd1, 32'h1111_0001);
      wait_ready("R9 ready");
      reg_write(2'd1, 32'h1111_0002);
      wait_idle("R9 end finish");
      chk("R9 end stop", status, exp_st(0,1,0,1,0,0,0));
      chk("R9 one word at end", lg_n - base, 1);
      chk_log("R9 log", base, 2'd2, FLASH - 4, 32'h1111_0001);

      // R10 lock
      lock_mask = 32'h0000_0020;
      base = lg_n;
      reg_write(2'd0, 5*2048 + 12);
      reg_write(2'd2, 32'd1);
      chk("R10 erase locked", status, exp_st(0,1,0,0,1,0,0));
      chk("R10 no erase strobe", {31'b0, fl_erase}, 32'd0);
      reg_write(2'd0, 5*2048 - 4);
      reg_write(2'd2, 32'd2);
      reg_write(2'd1, 32'h2222_0001);
      wait_ready("R10 ready");
      reg_write(2'd1, 32'h2222_0002);
      wait_idle("R10 finish");
      chk("R10 stream stops at lock", status, exp_st(0,1,0,0,1,0,0));
      chk("R10 one word", lg_n - base, 1);
      chk_log("R10 log", base, 2'd2, 5*2048 - 4, 32'h2222_0001);
      lock_mask = '0;

      // R12 abort by interrupt
      model_dly = 50;
      base = lg_n;
      reg_write(2'd0, 32'h0);
      reg_write(2'd2, 32'd1);
      chk("R13 locked cleared on accept", status, exp_st(1,1,0,0,0,0,0));
      repeat (5) @(negedge clk);
      irq = 1'b1;
      @(negedge clk);
      irq = 1'b0;
      chk("R12 aborted", status, exp_st(0,1,0,0,0,1,0));
      chk("R12 strobe dropped", {31'b0, fl_erase}, 32'd0);
      chk("R12 nothing logged", lg_n - base, 0);
      model_dly = 4;
      reg_write(2'd2, 32'd1);
      chk("R13 aborted cleared", status, exp_st(1,1,0,0,0,0,0));
      for (int i = 0; i < 40 && !fl_done; i++) @(negedge clk);
      irq = 1'b1;
      @(negedge clk);
      irq = 1'b0;
      chk("R12 done wins", status, exp_st(0,1,0,0,0,0,0));
      chk("R12 erase logged", lg_n - base, 1);
      model_dly = 3;

      // R4 R6 random streams
      for (int it = 0; it < 8; it++) begin
         int n;
         logic [31:0] a;
         logic [31:0] d [4];
         n    = 1 + int'($urandom % 4);
         a    = ($urandom % ((FLASH - 16) / 4)) * 4;
         base = lg_n;
         reg_write(2'd0, a);
         reg_write(2'd2, 32'd2);
         for (int k = 0; k < n; k++) begin
            d[k] = $urandom;
            reg_write(2'd1, d[k]);
            wait_ready("R2 random ready");
         end
         wait_idle("R6 random finish");
         chk("R4 random count", lg_n - base, n);
         for (int k = 0; k < n; k++)
            chk_log("R4 random word", base + k, 2'd2, a + 4*k, d[k]);
         chk("R6 random timeout", status, exp_st(0,1,1,0,0,0,0));
      end

      run_done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule